// File: doc/BRIEF.md
# Incremental ADC Digital Controller

This block is the digital back end of a first-order incremental converter. It runs on a single data clock and performs four jobs. It generates the two non-overlapping integrator phase clocks at one quarter of that rate. It sequences each conversion as a calculation/reset interval followed by an integrate window. It steers the reference polarity from the comparator. It counts the data clocks in which an external switched-capacitor integrator reports a positive output.

At the end of every window the count is scaled into an N-bit code. The code is presented as either a signed or an unsigned value. A data-ready flag announces the new code, and a sticky overrun flag records codes that replaced unread ones. One 16-bit timer times both the window and the programmable dead time. The window is 2^(N+2) data clocks, so the sample rate is the data clock divided by 2^(N+2) plus the effective dead time.

Software starts a run with a sample-count request. A request of zero converts until stopped. A request of n produces exactly n codes and then goes idle.

Top module: `incadc_ctrl`

## Requirements
- R1: The resolution input is clamped to the range 7..13: below 7 acts as 7, above 13 acts as 13. It is latched when a run starts. If the clamped value differs from the latched one while running, the run is aborted on the next clock edge and no result is posted.
- R2: While running, phi1 is high in the first cycle and phi2 in the third cycle of every group of four data clocks. Each integrate window begins a new group, so a window holds exactly 2^(N+2)/4 phi1 pulses. The two are never high together, and both are low while idle.
- R3: After an accepted start, intReset stays high for the effective dead time. It then goes low for exactly 2^(N+2) data clocks, and this pattern repeats for the rest of the run.
- R4: The effective dead time is calcTime, with two exceptions: 0 is raised to 1, and a value that would make the period 2^(N+2) + dead time exceed 65535 is saturated to 65535 − 2^(N+2).
- R5: The raw count is the number of clocks in the integrate window with compPos high. The unsigned code is the raw count shifted right by 2, clamped to 2^N − 1.
- R6: With signedFmt = 0 the result is the code zero-extended to 13 bits. With signedFmt = 1 it is the code minus 2^(N−1), sign-extended to 13 bits, in two's complement.
- R7: cmpLe selects whether the timer compare is "less than or equal" (compare value 2^(N+2) − 1) or "strictly less than" (compare value 2^(N+2)). Both modes give the same window length.
- R8: In every cycle with phi1 high, refSub takes the value of compPos (1 means subtract the reference). It holds that value in other cycles.
- R9: sampleCount = n > 0 yields exactly n results, after which busy falls in the cycle that posts the last one. sampleCount = 0 converts until stopped.
- R10: dataReady rises in the cycle where intReset returns high at the end of a window, and the new result is visible in that same cycle. A newer result overwrites an unread one. readAck clears dataReady on the next edge.
- R11: overrun is set when a result is posted while dataReady is still set and not being acknowledged. It stays set until a start is accepted.
- R12: A start pulse while busy has no effect. A stop pulse while busy drops busy on the next edge and posts no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resSel | input | 4 | Requested resolution N |
| calcTime | input | 16 | Requested dead time in data clocks |
| sampleCount | input | 8 | Results per run, 0 = continuous |
| startPulse | input | 1 | Start a run when idle |
| stopPulse | input | 1 | Abort the running conversion |
| cmpLe | input | 1 | Timer compare mode: 1 = less-or-equal, 0 = less-than |
| signedFmt | input | 1 | Result format: 1 = signed, 0 = unsigned |
| readAck | input | 1 | Clears dataReady |
| compPos | input | 1 | Comparator: integrator output positive |
| busy | output | 1 | A run is in progress |
| phi1 | output | 1 | Integrator sampling phase clock |
| phi2 | output | 1 | Integrator transfer phase clock |
| intReset | output | 1 | Integrator reset / counter gated off |
| refSub | output | 1 | Reference polarity: 1 = subtract |
| result | output | 13 | Latest code, format per signedFmt |
| dataReady | output | 1 | New result available |
| overrun | output | 1 | Sticky: a result replaced an unread one |

## Verification
The bench sweeps resolutions 7 to 9 with all-low, all-high, alternating, sparse and half-window comparator patterns. It alternates both formats and both compare modes, and computes each code from the ones it drove during the windows it saw. The corners it targets are these. Full-scale input must clamp to 2^N − 1 rather than wrap to zero, and a width error would show as a zero code at full scale at N = 13. The dead time must be saturated or raised from zero; a wrong bound would let the period timer wrap and give a very long or very short reset interval. The less-or-equal mode must not add an extra window clock, which would shift every code. A mid-run resolution change or stop must never post a stale code. Restarting while busy must not restart the timer, which would move the posting cycle.

// File: rtl/incadc_pkg.sv
package incadc_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;   // run accepted this cycle
    logic integ;   // integrate window active
    logic accClr;  // clear accumulator before a window
    logic post;    // last window clock: capture result
  } seqStrobes_t;
endpackage

// File: rtl/incadc_seq.sv
module incadc_seq
  import incadc_pkg::*;
#(
  parameter int RES_W   = 4,
  parameter int TMR_W   = 16,
  parameter int CNT_W   = 8,
  parameter int RES_MIN = 7,
  parameter int RES_MAX = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RES_W-1:0] resSel,
  input  logic [TMR_W-1:0] calcTime,
  input  logic [CNT_W-1:0] sampleCount,
  input  logic             startPulse,
  input  logic             stopPulse,
  input  logic             cmpLe,
  output seqStrobes_t      strb,
  output logic [RES_W-1:0] resAct,
  output logic             busy,
  output logic             phi1,
  output logic             phi2,
  output logic             intReset
);
  localparam logic [TMR_W:0] TMR_MAX = {1'b0, {TMR_W{1'b1}}};
  localparam logic [TMR_W:0] ONE_W   = {{TMR_W{1'b0}}, 1'b1};

  logic [RES_W-1:0] resEff;
  logic [TMR_W:0]   winNew, winAct, maxCalc, lastTick, cmpVal, calcWide;
  logic [TMR_W-1:0] calcNext, calcAct, tmr;
  logic [CNT_W-1:0] left;
  logic             cont;
  logic [1:0]       phase;
  logic             inWin, integ, abort, endWin, wrap, accept;

  always_comb begin
    if (resSel < RES_W'(RES_MIN))      resEff = RES_W'(RES_MIN);
    else if (resSel > RES_W'(RES_MAX)) resEff = RES_W'(RES_MAX);
    else                               resEff = resSel;

    winNew   = ONE_W << (resEff + RES_W'(2));
    maxCalc  = TMR_MAX - winNew;
    calcWide = {1'b0, calcTime};
    if (calcTime == '0)          calcNext = TMR_W'(1);
    else if (calcWide > maxCalc) calcNext = maxCalc[TMR_W-1:0];
    else                         calcNext = calcTime;

    winAct   = ONE_W << (resAct + RES_W'(2));
    lastTick = winAct + {1'b0, calcAct} - 1'b1;
    cmpVal   = cmpLe ? (winAct - 1'b1) : winAct;
    inWin    = cmpLe ? ({1'b0, tmr} <= cmpVal) : ({1'b0, tmr} < cmpVal);
    integ    = busy && inWin;
    abort    = busy && (stopPulse || (resEff != resAct));
    endWin   = integ && ({1'b0, tmr} == (winAct - 1'b1));
    wrap     = ({1'b0, tmr} == lastTick);
    accept   = startPulse && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      tmr     <= '0;
      phase   <= '0;
      resAct  <= RES_W'(RES_MIN);
      calcAct <= TMR_W'(1);
      left    <= '0;
      cont    <= 1'b0;
    end else if (!busy) begin
      if (startPulse) begin
        busy    <= 1'b1;
        resAct  <= resEff;
        calcAct <= calcNext;
        tmr     <= winNew[TMR_W-1:0];   // begin in the dead interval
        phase   <= '0;
        left    <= sampleCount;
        cont    <= (sampleCount == '0);
      end
    end else if (abort) begin
      busy <= 1'b0;
    end else begin
      if (endWin && !cont) begin
        left <= left - 1'b1;
        if (left == CNT_W'(1)) busy <= 1'b0;
      end
      if (wrap) begin
        tmr   <= '0;
        phase <= '0;
      end else begin
        tmr   <= tmr + 1'b1;
        phase <= phase + 1'b1;
      end
    end
  end

  assign strb.start  = accept;
  assign strb.integ  = integ;
  assign strb.accClr = accept || (busy && wrap);
  assign strb.post   = endWin && !abort;

  assign phi1     = busy && (phase == 2'd0);
  assign phi2     = busy && (phase == 2'd2);
  assign intReset = !integ;
endmodule

// File: rtl/incadc_dp.sv
module incadc_dp
  import incadc_pkg::*;
#(
  parameter int RES_W   = 4,
  parameter int RES_MAX = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strb,
  input  logic [RES_W-1:0]   resAct,
  input  logic               compPos,
  input  logic               phi1,
  input  logic               signedFmt,
  input  logic               readAck,
  output logic               refSub,
  output logic [RES_MAX-1:0] result,
  output logic               dataReady,
  output logic               overrun
);
  localparam int ACC_W = RES_MAX + 3;

  logic [ACC_W-1:0]   acc, finalCnt, rawCode, fullCode, code, half;
  logic [RES_MAX-1:0] resultNext;

  always_comb begin
    finalCnt   = acc + ACC_W'(compPos);
    rawCode    = finalCnt >> 2;
    fullCode   = ACC_W'(1) << resAct;
    code       = (rawCode >= fullCode) ? (fullCode - 1'b1) : rawCode;
    half       = ACC_W'(1) << (resAct - 1'b1);
    resultNext = signedFmt ? RES_MAX'(code - half) : RES_MAX'(code);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      refSub    <= 1'b0;
      result    <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strb.accClr)     acc <= '0;
      else if (strb.integ) acc <= finalCnt;

      if (phi1) refSub <= compPos;

      if (strb.post) result <= resultNext;

      if (strb.post)   dataReady <= 1'b1;
      else if (readAck) dataReady <= 1'b0;

      if (strb.post && dataReady && !readAck) overrun <= 1'b1;
      else if (strb.start)                     overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/incadc_ctrl.sv
module incadc_ctrl
  import incadc_pkg::*;
#(
  parameter int RES_W   = 4,
  parameter int TMR_W   = 16,
  parameter int CNT_W   = 8,
  parameter int RES_MIN = 7,
  parameter int RES_MAX = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RES_W-1:0]   resSel,
  input  logic [TMR_W-1:0]   calcTime,
  input  logic [CNT_W-1:0]   sampleCount,
  input  logic               startPulse,
  input  logic               stopPulse,
  input  logic               cmpLe,
  input  logic               signedFmt,
  input  logic               readAck,
  input  logic               compPos,
  output logic               busy,
  output logic               phi1,
  output logic               phi2,
  output logic               intReset,
  output logic               refSub,
  output logic [RES_MAX-1:0] result,
  output logic               dataReady,
  output logic               overrun
);
  seqStrobes_t      strb;
  logic [RES_W-1:0] resAct;

  incadc_seq #(
    .RES_W(RES_W), .TMR_W(TMR_W), .CNT_W(CNT_W),
    .RES_MIN(RES_MIN), .RES_MAX(RES_MAX)
  ) u_seq (
    .clk(clk), .rstN(rstN), .resSel(resSel), .calcTime(calcTime),
    .sampleCount(sampleCount), .startPulse(startPulse), .stopPulse(stopPulse),
    .cmpLe(cmpLe), .strb(strb), .resAct(resAct), .busy(busy),
    .phi1(phi1), .phi2(phi2), .intReset(intReset)
  );

  incadc_dp #(.RES_W(RES_W), .RES_MAX(RES_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .resAct(resAct), .compPos(compPos),
    .phi1(phi1), .signedFmt(signedFmt), .readAck(readAck), .refSub(refSub),
    .result(result), .dataReady(dataReady), .overrun(overrun)
  );
endmodule

// File: rtl/incadc_ctrl_chk.sv
module incadc_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic stopPulse,
  input logic readAck,
  input logic compPos,
  input logic busy,
  input logic phi1,
  input logic phi2,
  input logic intReset,
  input logic refSub,
  input logic dataReady,
  input logic overrun
);
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(phi1 && phi2)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (intReset && !phi1 && !phi2)); // R2
  AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    phi1 |=> (refSub == $past(compPos))); // R8
  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> (intReset && $past(!intReset))); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && intReset) |=> !dataReady); // R10
  AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && busy) |=> !busy); // R12
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !(startPulse && !busy)) |=> overrun); // R11
endmodule

bind incadc_ctrl incadc_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
  .readAck(readAck), .compPos(compPos), .busy(busy), .phi1(phi1), .phi2(phi2),
  .intReset(intReset), .refSub(refSub), .dataReady(dataReady), .overrun(overrun)
);

// File: tb/incadc_ctrl_test.sv
`timescale 1ns/1ps
module incadc_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  resSel = 4'd7;
  logic [15:0] calcTime = 16'd4;
  logic [7:0]  sampleCount = 8'd1;
  logic        startPulse = 1'b0, stopPulse = 1'b0, cmpLe = 1'b0;
  logic        signedFmt = 1'b0, readAck = 1'b0, compPos = 1'b0;
  logic        busy, phi1, phi2, intReset, refSub, dataReady, overrun;
  logic [12:0] result;

  int nTests = 0, nFail = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  incadc_ctrl uut (
    .clk(clk), .rstN(rstN), .resSel(resSel), .calcTime(calcTime),
    .sampleCount(sampleCount), .startPulse(startPulse), .stopPulse(stopPulse),
    .cmpLe(cmpLe), .signedFmt(signedFmt), .readAck(readAck), .compPos(compPos),
    .busy(busy), .phi1(phi1), .phi2(phi2), .intReset(intReset), .refSub(refSub),
    .result(result), .dataReady(dataReady), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int calcEff(input int n, input int c);
    int w = 1 << (n + 2);
    if (c == 0) return 1;
    if (c > 65535 - w) return 65535 - w;
    return c;
  endfunction

  function automatic int expCode(input int n, input int ones, input bit fmt);
    int c = ones >> 2;
    if (c > (1 << n) - 1) c = (1 << n) - 1;
    if (fmt) c = c - (1 << (n - 1));
    return c & 32'h1fff;
  endfunction

  function automatic bit patBit(input int pat, input int i, input int w);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return i[0];
      3: return ((i * 7 + 3) % 5) < 2;
      default: return i < w / 2;
    endcase
  endfunction

  // single conversion with full timing, code, phase and polarity checks
  task automatic convert(input int n, input int resIn, input int calc, input int pat,
                         input bit fmt, input bit le);
    int w = 1 << (n + 2);
    int dead = 0, win = 0, ones = 0, p1 = 0, refBad = 0;
    bit pend = 0, pendVal = 0;
    @(negedge clk);
    resSel = 4'(resIn); calcTime = 16'(calc); sampleCount = 8'd1;
    signedFmt = fmt; cmpLe = le; compPos = 1'b0; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    while (intReset && dead < 70000) begin dead++; @(negedge clk); end
    while (!intReset && win < 70000) begin
      if (pend && refSub != pendVal) refBad++;
      pend = 1'b0;
      compPos = patBit(pat, win, w);
      if (compPos) ones++;
      if (phi1) begin p1++; pend = 1'b1; pendVal = compPos; end
      win++;
      @(negedge clk);
    end
    compPos = 1'b0;
    chk(dead == calcEff(n, calc), "R4 dead time", dead, calcEff(n, calc));
    chk(win == w, le ? "R7 window le" : "R3 window", win, w);
    chk(p1 == w / 4, "R2 phi1 pulses", p1, w / 4);
    chk(refBad == 0, "R8 polarity", refBad, 0);
    chk(dataReady == 1'b1, "R10 ready", dataReady, 1);
    chk(int'(result) == expCode(n, ones, fmt), fmt ? "R6 signed code" : "R5 code",
        result, expCode(n, ones, fmt));
    chk(busy == 1'b0, "R9 single run ends", busy, 0);
    chk(overrun == 1'b0, "R11 cleared by start", overrun, 0);
    readAck = 1'b1; @(negedge clk); readAck = 1'b0;
    chk(dataReady == 1'b0, "R10 ack", dataReady, 1'b0);
  endtask

  // run for a number of cycles, counting results; compPos high until first result
  task automatic runFor(input int ncyc, input bit doAck, output int posts);
    bit prev = 0;
    posts = 0;
    for (int i = 0; i < ncyc; i++) begin
      if (dataReady && !prev) posts++;
      prev = dataReady;
      readAck = doAck && dataReady;
      compPos = (posts == 0);
      @(negedge clk);
    end
    readAck = 1'b0; compPos = 1'b0;
  endtask

  task automatic startRun(input int res, input int calc, input int cnt);
    @(negedge clk);
    resSel = 4'(res); calcTime = 16'(calc); sampleCount = 8'(cnt);
    signedFmt = 1'b0; cmpLe = 1'b0; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  initial begin
    int posts, k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R12 reset busy", busy, 0);
    chk(dataReady == 1'b0 && overrun == 1'b0, "R10 reset flags", {dataReady, overrun}, 0);
    chk(intReset && !phi1 && !phi2, "R2 reset clocks", {intReset, phi1, phi2}, 4);
    chk(result == '0, "R6 reset result", result, 0);

    for (int n = 7; n <= 9; n++)
      for (int pat = 0; pat < 5; pat++)
        convert(n, n, 3 + pat, pat, 1'((pat + n) % 2), 1'(pat % 2));

    convert(7, 3, 2, 3, 1'b0, 1'b0);        // R1 low clamp
    convert(7, 7, 0, 1, 1'b1, 1'b0);        // R4 zero dead time
    convert(13, 13, 5, 1, 1'b1, 1'b1);      // R5 full-scale clamp at max width

    // R9: two results then stop
    startRun(7, 10, 2);
    runFor(10 + 2 * 522 + 40, 1'b1, posts);
    chk(posts == 2, "R9 count two", posts, 2);
    chk(busy == 1'b0, "R9 idle after two", busy, 0);

    // R9 continuous, then R12 stop
    startRun(7, 10, 0);
    runFor(10 + 3 * 522 + 20, 1'b1, posts);
    chk(posts == 3, "R9 continuous", posts, 3);
    chk(busy == 1'b1, "R9 still running", busy, 1);
    stopPulse = 1'b1; @(negedge clk); stopPulse = 1'b0;
    chk(busy == 1'b0, "R12 stop", busy, 0);
    runFor(700, 1'b0, posts);
    chk(posts == 0 && dataReady == 1'b0, "R12 no result after stop", posts, 0);

    // R11 overrun and R10 overwrite
    startRun(7, 10, 2);
    runFor(10 + 2 * 522 + 40, 1'b0, posts);
    chk(overrun == 1'b1, "R11 overrun set", overrun, 1);
    chk(result == 13'd0, "R10 overwrite", result, 0);
    readAck = 1'b1; @(negedge clk); readAck = 1'b0;
    chk(dataReady == 1'b0 && overrun == 1'b1, "R11 sticky", {dataReady, overrun}, 1);

    // R12 start while busy ignored: posting cycle unchanged
    startRun(7, 10, 1);
    k = 1;
    while (!dataReady && k < 5000) begin
      @(negedge clk); k++;
      startPulse = (k == 100);
    end
    startPulse = 1'b0;
    chk(k == 523, "R12 restart ignored", k, 523);
    readAck = 1'b1; @(negedge clk); readAck = 1'b0;

    // R1 resolution change aborts
    startRun(8, 10, 1);
    repeat (50) @(negedge clk);
    resSel = 4'd9;
    @(negedge clk);
    chk(busy == 1'b0, "R1 abort on change", busy, 0);
    runFor(1200, 1'b0, posts);
    chk(dataReady == 1'b0, "R1 no result", dataReady, 0);

    convert(7, 7, 65535, 2, 1'b0, 1'b1);    // R4 saturation

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 199000 && !finished) begin
        nTests++; nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 199000);
        $display("[TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end
endmodule